// File: doc/BRIEF.md
# I2C Master Write Sequencer with Status Codes

This block performs a complete byte-oriented I2C master write. When an idle start pulse arrives with a 7-bit target address and a byte count, it puts a START on the bus and sends the address byte with the direction bit forced to write. It then sends the requested number of data bytes and finishes with a STOP. The data bytes come from an external buffer through a combinational read port. SDA and SCL are open-drain, so the block only drives output enables; an enable of 1 pulls the line low. The bit rate comes from a quarter-bit prescaler, which is fine enough for 400 kHz operation from a typical system clock. The block honours clock stretching.

Each outcome is reported as an 8-bit status code. An active-low interrupt goes with every final outcome and stays asserted until the host acknowledges it or starts a new transfer. A programmable watchdog counts prescaler ticks, so a transfer that stalls (for example, a target holding SCL low) ends with a timeout code. A byte count that is out of range is rejected before any bus activity.

Top module: `i2c_wr_seq`

## Requirements
- R1: After reset, status_o is 0xF0, irq_no is high and both scl_oe_o and sda_oe_o are low.
- R2: A start_i pulse in idle with a count in 1..MAX_BYTES (96) sets status_o to 0xF3 and irq_no high on the next clock. Both stay that way until the transfer ends. A start_i while busy is ignored.
- R3: The bus sees START, then the address byte {addr_i, 1'b0} MSB first, then count_i data bytes read from rd_data_i at rd_addr_o = 0, 1, ..., count_i-1, then STOP. The block releases SDA during every ninth (acknowledge) clock.
- R4: When every byte is acknowledged, the block issues STOP and then sets status_o to 0xF0 and irq_no low.
- R5: When the address byte is not acknowledged (SDA high in the ninth clock), the block sends no data, issues STOP, and reports 0xF1 with irq_no low.
- R6: When a data byte is not acknowledged, no further byte is sent, STOP is issued, and the block reports 0xF2 with irq_no low.
- R7: A start_i with count_i of 0 or greater than 96 gives status 0xF9 and irq_no low on the next clock. Both output enables stay low.
- R8: With tmo_i nonzero, a transfer still busy after tmo_i prescaler ticks releases both lines and reports 0xF8 with irq_no low. When tmo_i is 0, the timeout is disabled.
- R9: One prescaler tick is div_i+1 clocks, and an unstretched SCL period is 4 ticks. While SCL is held low externally, the block waits with status 0xF3.
- R10: irq_no stays low until an irq_ack_i pulse or an accepted start_i. An acknowledge does not change status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a write transfer (accepted in idle only) |
| addr_i | input | 7 | Target address |
| count_i | input | CW (8) | Number of data bytes |
| div_i | input | DW (16) | Quarter-bit period minus one, in clocks |
| tmo_i | input | TW (16) | Timeout limit in prescaler ticks, 0 disables |
| irq_ack_i | input | 1 | Host acknowledge, clears the interrupt |
| rd_addr_o | output | AW (7) | Buffer read index |
| rd_data_i | input | 8 | Buffer byte at rd_addr_o |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| status_o | output | 8 | Result or busy code |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench targets the two count limits, 0 and 97, which must be rejected without any bus activity, and the 96-byte maximum, which must run in full. A design that compared against the wrong bound would either start the bus or refuse a legal transfer. The bench places a missing acknowledge on the address byte and on a middle data byte. A design that confused the two cases would return the wrong code, and a design that kept sending after the missing acknowledge would produce extra bytes, which the scoreboard reports as unexpected. The bench holds SCL low twice: once with the timeout disabled, where a wrong design would stop waiting, and once with a limit set, where a wrong design would hang or leave the lines driven. It also checks that the interrupt stays asserted until it is acknowledged.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} st_e;

  localparam logic [7:0] STAT_OK        = 8'hF0;
  localparam logic [7:0] STAT_ADDR_NACK = 8'hF1;
  localparam logic [7:0] STAT_DATA_NACK = 8'hF2;
  localparam logic [7:0] STAT_BUSY      = 8'hF3;
  localparam logic [7:0] STAT_TMO       = 8'hF8;
  localparam logic [7:0] STAT_BAD_CNT   = 8'hF9;
endpackage

// File: rtl/i2c_wr_tick.sv
module i2c_wr_tick #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R9: ticks are spaced div_i+1 clocks apart
  a_r9_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/i2c_wr_tmo.sv
module i2c_wr_tmo #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;
  logic          hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (run_i && tick_i && limit_i != '0) begin
      if (cnt_q == limit_i - 1'b1) begin
        cnt_q <= '0;
        hit_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        hit_q <= 1'b0;
      end
    end else begin
      hit_q <= 1'b0;
    end
  end

  assign hit_o = hit_q;

  // R8: a zero limit never expires
  a_r8_zero_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i == '0) |=> !hit_o);
endmodule

// File: rtl/i2c_wr_irq.sv
module i2c_wr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_no = ~irq_q;

  // R10: interrupt held until acknowledge or new start
  a_r10_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !clr_i) |=> !irq_no);
endmodule

// File: rtl/i2c_wr_seq.sv
module i2c_wr_seq
  import i2c_wr_pkg::*;
#(
  parameter int MAX_BYTES = 96,
  parameter int CW        = 8,
  parameter int DW        = 16,
  parameter int TW        = 16,
  localparam int AW       = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [6:0]    addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [DW-1:0] div_i,
  input  logic [TW-1:0] tmo_i,
  input  logic          irq_ack_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic [7:0]    status_o,
  output logic          irq_no
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_BYTES);

  st_e           st_q;
  logic [1:0]    q_q;
  logic [7:0]    sh_q;
  logic [3:0]    bit_q;
  logic          first_q;
  logic [CW-1:0] left_q;
  logic [AW-1:0] idx_q;
  logic          scl_oe_q, sda_oe_q;
  logic [7:0]    status_q, code_q;
  logic [1:0]    scl_sync_q, sda_sync_q;
  logic          scl_s, sda_s;
  logic          tick, tmo_hit;
  logic          bad_cnt, accept, busy, fin_ok, irq_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= 2'b11;
      sda_sync_q <= 2'b11;
    end else begin
      scl_sync_q <= {scl_sync_q[0], scl_i};
      sda_sync_q <= {sda_sync_q[0], sda_i};
    end
  end
  assign scl_s = scl_sync_q[1];
  assign sda_s = sda_sync_q[1];

  assign bad_cnt = (count_i == '0) || (count_i > MAX_C);
  assign accept  = (st_q == ST_IDLE) && start_i;
  assign busy    = (st_q != ST_IDLE);
  assign fin_ok  = (st_q == ST_STOP) && tick && (q_q == 2'd3) && scl_s;
  assign irq_set = (tmo_hit && busy) || fin_ok || (accept && bad_cnt);

  i2c_wr_tick #(.DW(DW)) u_tick (
    .clk_i, .rst_ni, .div_i, .tick_o(tick)
  );

  i2c_wr_tmo #(.TW(TW)) u_tmo (
    .clk_i, .rst_ni, .clear_i(accept), .run_i(busy), .tick_i(tick),
    .limit_i(tmo_i), .hit_o(tmo_hit)
  );

  i2c_wr_irq u_irq (
    .clk_i, .rst_ni, .set_i(irq_set), .clr_i(irq_ack_i || accept), .irq_no
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      q_q      <= '0;
      sh_q     <= '0;
      bit_q    <= '0;
      first_q  <= 1'b0;
      left_q   <= '0;
      idx_q    <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      status_q <= STAT_OK;
      code_q   <= STAT_OK;
    end else if (tmo_hit && busy) begin
      st_q     <= ST_IDLE;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      status_q <= STAT_TMO;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (bad_cnt) status_q <= STAT_BAD_CNT;
          else begin
            status_q <= STAT_BUSY;
            st_q     <= ST_START;
            q_q      <= '0;
            sh_q     <= {addr_i, 1'b0};
            bit_q    <= '0;
            first_q  <= 1'b1;
            left_q   <= count_i;
            idx_q    <= '0;
          end
        end
        ST_START: if (tick) begin
          unique case (q_q)
            2'd0:    q_q <= 2'd1;
            2'd1:    begin sda_oe_q <= 1'b1; q_q <= 2'd2; end
            default: begin scl_oe_q <= 1'b1; q_q <= 2'd0; st_q <= ST_BIT; end
          endcase
        end
        ST_BIT: if (tick) begin
          unique case (q_q)
            2'd0: q_q <= 2'd1;
            2'd1: begin
              sda_oe_q <= (bit_q == 4'd8) ? 1'b0 : ~sh_q[7];
              q_q      <= 2'd2;
            end
            2'd2: begin scl_oe_q <= 1'b0; q_q <= 2'd3; end
            default: if (scl_s) begin
              scl_oe_q <= 1'b1;
              q_q      <= 2'd0;
              if (bit_q != 4'd8) begin
                sh_q  <= {sh_q[6:0], 1'b0};
                bit_q <= bit_q + 1'b1;
              end else if (sda_s) begin
                code_q <= first_q ? STAT_ADDR_NACK : STAT_DATA_NACK;
                st_q   <= ST_STOP;
              end else if (left_q != '0) begin
                sh_q    <= rd_data_i;
                idx_q   <= idx_q + 1'b1;
                left_q  <= left_q - 1'b1;
                bit_q   <= '0;
                first_q <= 1'b0;
              end else begin
                code_q <= STAT_OK;
                st_q   <= ST_STOP;
              end
            end
          endcase
        end
        default: if (tick) begin // ST_STOP
          unique case (q_q)
            2'd0: q_q <= 2'd1;
            2'd1: begin sda_oe_q <= 1'b1; q_q <= 2'd2; end
            2'd2: begin scl_oe_q <= 1'b0; q_q <= 2'd3; end
            default: if (scl_s) begin
              sda_oe_q <= 1'b0;
              st_q     <= ST_IDLE;
              status_q <= code_q;
            end
          endcase
        end
      endcase
    end
  end

  assign rd_addr_o = idx_q;
  assign scl_oe_o  = scl_oe_q;
  assign sda_oe_o  = sda_oe_q;
  assign status_o  = status_q;

  // R2: busy code and no interrupt for the whole transfer
  a_r2_busy_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (status_o == STAT_BUSY && irq_no));

  // R7: illegal count rejected without bus activity
  a_r7_bad_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bad_cnt) |=> (status_o == STAT_BAD_CNT && !irq_no && !busy
                             && !scl_oe_o && !sda_oe_o));

  // R8: timeout releases the bus and reports
  a_r8_tmo_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_hit && busy) |=> (status_o == STAT_TMO && !scl_oe_o && !sda_oe_o && !irq_no));

  // R3: SDA only changes while SCL is pulled low during bits
  a_r3_sda_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIT && $past(st_q) == ST_BIT && !scl_oe_o && !$past(scl_oe_o))
      |-> $stable(sda_oe_o));
endmodule

// File: tb/i2c_wr_seq_tb.sv
module i2c_wr_seq_tb;
  localparam int MAXB = 96;
  localparam int CW   = 8;
  localparam int DW   = 16;
  localparam int TW   = 16;
  localparam int AW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          start;
  logic [6:0]    addr;
  logic [CW-1:0] count;
  logic [DW-1:0] div;
  logic [TW-1:0] tmo;
  logic          irq_ack;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          scl_oe, sda_oe;
  logic [7:0]    status;
  logic          irq_n;
  logic          hold_scl, sda_drv;
  logic          scl_bus, sda_bus;
  logic [7:0]    seed;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  function automatic logic [7:0] buf_byte(logic [AW-1:0] a, logic [7:0] s);
    return ({1'b0, a} * 8'd37) ^ s;
  endfunction

  assign scl_bus = ~(scl_oe | hold_scl);
  assign sda_bus = ~(sda_oe | sda_drv);
  assign rd_data = buf_byte(rd_addr, seed);

  i2c_wr_seq #(.MAX_BYTES(MAXB), .CW(CW), .DW(DW), .TW(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .count_i(count),
    .div_i(div), .tmo_i(tmo), .irq_ack_i(irq_ack), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe), .status_o(status), .irq_no(irq_n)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // target model and scoreboard monitor
  logic [7:0] exp_q[$];
  bit         in_tx = 0;
  bit         ack_addr = 1;
  int         nack_at = 0;
  int         bitc = 0, bytec = 0, stops = 0, starts = 0, rise_n = 0;
  int         rise_cyc[4];
  logic [7:0] shr = '0;

  always @(negedge sda_bus) if (scl_bus) begin
    in_tx = 1; bitc = 0; bytec = 0; rise_n = 0; starts++;
  end
  always @(posedge sda_bus) if (scl_bus && in_tx) begin
    in_tx = 0; stops++;
  end
  always @(posedge scl_bus) if (in_tx) begin
    if (rise_n < 4) rise_cyc[rise_n] = cyc;
    rise_n++;
    if (bitc < 8) begin
      shr = {shr[6:0], sda_bus};
      bitc++;
    end else begin
      if (exp_q.size() == 0) chk("R3 unexpected byte", 1, 0);
      else chk("R3 byte", int'(shr), int'(exp_q.pop_front()));
      bitc = 0;
      bytec++;
    end
  end
  always @(negedge scl_bus) begin
    if (in_tx && bitc == 8)
      sda_drv = (bytec == 0) ? ack_addr : (bytec != nack_at);
    else
      sda_drv = 1'b0;
  end

  task automatic pulse_start(logic [6:0] a, int n, logic [TW-1:0] t);
    @(negedge clk);
    addr = a; count = CW'(n); tmo = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push_exp(logic [6:0] a, int n, bit aack, int nk);
    exp_q.push_back({a, 1'b0});
    if (aack)
      for (int k = 1; k <= n; k++) begin
        exp_q.push_back(buf_byte(AW'(k - 1), seed));
        if (k == nk) break;
      end
  endtask

  task automatic wait_done();
    int g = 0;
    while (status == 8'hF3 && g < 40000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic run_write(logic [6:0] a, int n, bit aack, int nk, logic [7:0] exp_st);
    int s0;
    seed = seed + 8'h3B;
    ack_addr = aack; nack_at = nk;
    push_exp(a, n, aack, nk);
    s0 = stops;
    pulse_start(a, n, '0);
    chk("R2 busy status", int'(status), 'hF3);
    chk("R2 irq released on start", int'(irq_n), 1);
    wait_done();
    chk("R4/R5/R6 final status", int'(status), int'(exp_st));
    chk("R4/R5/R6 irq asserted", int'(irq_n), 0);
    chk("R3 all bytes seen", exp_q.size(), 0);
    chk("R3 stop issued", stops - s0, 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int s0, t0;
    bit touched;
    rst_n = 0; start = 0; addr = '0; count = '0; div = 16'd3; tmo = '0;
    irq_ack = 0; hold_scl = 0; sda_drv = 0; seed = 8'h11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", int'(status), 'hF0);
    chk("R1 reset irq", int'(irq_n), 1);
    chk("R1 reset scl_oe", int'(scl_oe), 0);
    chk("R1 reset sda_oe", int'(sda_oe), 0);

    // R4 plain success, R9 bit period
    run_write(7'h2A, 3, 1, 0, 8'hF0);
    chk("R9 scl period", rise_cyc[2] - rise_cyc[1], 16);

    // R10 interrupt hold and acknowledge
    repeat (20) @(negedge clk);
    chk("R10 irq held", int'(irq_n), 0);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R10 irq cleared by ack", int'(irq_n), 1);
    chk("R10 status kept", int'(status), 'hF0);

    // R5 address not acknowledged
    run_write(7'h51, 4, 0, 0, 8'hF1);
    // R6 data byte 2 not acknowledged
    run_write(7'h13, 4, 1, 2, 8'hF2);

    // R7 illegal counts
    for (int v = 0; v < 2; v++) begin
      s0 = starts;
      touched = 0;
      pulse_start(7'h22, v == 0 ? 0 : MAXB + 1, '0);
      chk("R7 bad count status", int'(status), 'hF9);
      chk("R7 bad count irq", int'(irq_n), 0);
      repeat (40) begin
        @(negedge clk);
        if (scl_oe || sda_oe) touched = 1;
      end
      chk("R7 no bus activity", int'(touched), 0);
      chk("R7 no start seen", starts - s0, 0);
    end

    // R7 upper bound legal, R3 full buffer walk
    run_write(7'h7F, MAXB, 1, 0, 8'hF0);

    // R2 start while busy ignored
    seed = seed + 8'h3B;
    ack_addr = 1; nack_at = 0;
    push_exp(7'h0C, 2, 1, 0);
    pulse_start(7'h0C, 2, '0);
    repeat (30) @(negedge clk);
    count = '0; start = 1; @(negedge clk); start = 0;
    chk("R2 start ignored while busy", int'(status), 'hF3);
    wait_done();
    chk("R2 busy run completes", int'(status), 'hF0);
    chk("R2 busy run bytes", exp_q.size(), 0);
    exp_q.delete();

    // R9 clock stretch with timeout disabled
    seed = seed + 8'h3B;
    push_exp(7'h35, 2, 1, 0);
    pulse_start(7'h35, 2, '0);
    @(negedge scl_bus);
    hold_scl = 1;
    repeat (1500) @(negedge clk);
    chk("R9 waits while stretched", int'(status), 'hF3);
    chk("R8 zero limit never fires", int'(irq_n), 1);
    hold_scl = 0;
    wait_done();
    chk("R9 stretched run completes", int'(status), 'hF0);
    chk("R9 stretched run bytes", exp_q.size(), 0);
    exp_q.delete();

    // R8 timeout with SCL held low
    pulse_start(7'h44, 3, 16'd40);
    t0 = cyc;
    @(negedge scl_bus);
    hold_scl = 1;
    while (cyc - t0 < 120) @(negedge clk);
    chk("R8 not yet expired", int'(status), 'hF3);
    while (cyc - t0 < 200) @(negedge clk);
    chk("R8 timeout status", int'(status), 'hF8);
    chk("R8 timeout irq", int'(irq_n), 0);
    chk("R8 scl released", int'(scl_oe), 0);
    chk("R8 sda released", int'(sda_oe), 0);
    hold_scl = 0;
    exp_q.delete();
    repeat (20) @(negedge clk);

    // R10 new start clears interrupt, recovers after timeout
    run_write(7'h60, 1, 1, 0, 8'hF0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule